// File: doc/BRIEF.md
# System Control Register Block with Exception Return

This block keeps the processor's system-control state: the Status word, the Config word, the free-running Count timer, and the two saved return addresses. The return address for a normal exception is held in EPC. The return address for an error-level exception is held in ErrorEPC. Software reaches these registers through a single read/write port that a 5-bit register number selects. Every register has its own masking. Status reads are filtered. Part of Config is fixed. Count reads add the time that has passed since the last Count access.

Three single-cycle command strobes act on the Status word:

- **Return** picks the return address and clears the matching exception-level bit.
- **Enable** sets the interrupt-enable bit, but only when the privilege and error state allows it.
- **Disable** clears the interrupt-enable bit, under the same condition.

A separate combinational output reports the coprocessor branch condition. It is formed from two 10-bit channel vectors: a completion-status vector and an enable vector.

The block accepts at most one operation per clock. If several arrive together, the order of precedence is write, then return, then enable, then disable.

Top module: `sysctl_regs`

## Requirements
- R1: After a synchronous reset, reads return 0 for Status, EPC and ErrorEPC, and `ret_valid` is 0. A read of Config returns 0x00000440.
- R2: Status is register 12 and stores all 32 written bits. A read returns the stored value ANDed with 0xF0C79C1F, so a write of 0xFFFFFFFF reads back as 0xF0C79C1F.
- R3: Config is register 16. Its bits 11:6 always hold 6'b010001, and every other bit is writable. A write of 0xFFFFFFFF reads back 0xFFFFF47F, and a write of 0 reads back 0x00000440.
- R4: Count is register 9. A write of V followed, k clocks later, by a read returns V+k modulo 2^32, and the register then holds that value. For example, a write of 0xFFFFFFFF read one clock later returns 0.
- R5: A Count read with zero elapsed cycles adds 1. The first clock after reset is such a case, so a Count read there returns 1.
- R6: A return with ERL (Status bit 2) set does four things. It sets `ret_pc` to ErrorEPC (register 30), clears ERL, leaves EXL (bit 1) unchanged, and raises `ret_valid` for the one cycle after the strobe.
- R7: A return with ERL clear does two things. It sets `ret_pc` to EPC (register 14) and clears EXL.
- R8: When at least one of EDI (bit 17), EXL (bit 1), ERL (bit 2) or KSU (bits 4:3) == 0 holds, enable sets EIE (bit 16) and disable clears it.
- R9: When none of the R8 conditions holds, enable and disable leave Status unchanged.
- R10: `cond_true` is 1 exactly when (`chan_done` OR NOT `chan_enable`) is all ones across the 10 bits. It is combinational.
- R11: Read data appears on `rd_data` at the first clock edge after `rd_en`. EPC and ErrorEPC store and return all 32 bits. Any other register number reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 5 | Register number for a read or write |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| eret_cmd | input | 1 | Exception-return strobe |
| ei_cmd | input | 1 | Enable-interrupt strobe |
| di_cmd | input | 1 | Disable-interrupt strobe |
| ret_pc | output | 32 | Selected return address |
| ret_valid | output | 1 | High for one cycle after a return |
| chan_done | input | 10 | Per-channel completion status |
| chan_enable | input | 10 | Per-channel condition enable |
| cond_true | output | 1 | Coprocessor branch condition |

## Verification
`rd_data`, `ret_pc` and `ret_valid` are registered, so each is due at the first rising edge after its strobe. The bench raises every strobe at a falling edge, holds it through one rising edge, and samples at the next falling edge. Count results depend on the exact spacing between a write and a read. The bench therefore counts idle falling edges between the two operations and computes the expected sum from that count. `cond_true` is combinational and is sampled one time unit after its inputs change.

// File: rtl/sysctl_pkg.sv
// Package: shared register numbers, Status bit positions and masks for the
// system control block. Assumes a 32-bit data path.
package sysctl_pkg;
    localparam int DW      = 32;
    localparam int SEL_W   = 5;

    localparam logic [SEL_W-1:0] SEL_COUNT  = 5'd9;
    localparam logic [SEL_W-1:0] SEL_STATUS = 5'd12;
    localparam logic [SEL_W-1:0] SEL_EPC    = 5'd14;
    localparam logic [SEL_W-1:0] SEL_CONFIG = 5'd16;
    localparam logic [SEL_W-1:0] SEL_ERREPC = 5'd30;

    localparam int ST_EXL    = 1;
    localparam int ST_ERL    = 2;
    localparam int ST_KSU_LO = 3;
    localparam int ST_KSU_HI = 4;
    localparam int ST_EIE    = 16;
    localparam int ST_EDI    = 17;

    localparam logic [DW-1:0] STATUS_RD_MASK = 32'hF0C7_9C1F;
    localparam logic [DW-1:0] CFG_FIX_MASK   = 32'h0000_0FC0;
    localparam logic [DW-1:0] CFG_FIX_VAL    = 32'h0000_0440;
endpackage

// File: rtl/sysctl_count.sv
// Count timer: a free-running cycle counter plus the software-visible Count
// register. A read adds the cycles elapsed since the last access (at least 1);
// a write loads the value. Both refresh the last-access stamp.
// Assumes read and write are never strobed in the same cycle.
module sysctl_count
    import sysctl_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_rd,
    input  logic          acc_wr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] count_rd
);
    logic [DW-1:0] cyc_q;
    logic [DW-1:0] last_q;
    logic [DW-1:0] count_q;
    logic [DW-1:0] elapsed;
    logic [DW-1:0] incr;

    // Elapsed time since the last access, never less than one.
    always_comb begin
        elapsed  = cyc_q - last_q;
        incr     = (elapsed == '0) ? {{(DW-1){1'b0}}, 1'b1} : elapsed;
        count_rd = count_q + incr;
    end

    // Cycle counter, Count value and last-access stamp.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q   <= '0;
            last_q  <= '0;
            count_q <= '0;
        end else begin
            cyc_q <= cyc_q + 1'b1;
            if (acc_wr) begin
                count_q <= wr_data;
                last_q  <= cyc_q;
            end else if (acc_rd) begin
                count_q <= count_rd;
                last_q  <= cyc_q;
            end
        end
    end

    AST_COUNT_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && !acc_wr) |=> (count_q != $past(count_q))); // R5
    AST_STAMP_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd || acc_wr) |=> (last_q == $past(cyc_q))); // R4
endmodule

// File: rtl/sysctl_state.sv
// Status, Config, EPC and ErrorEPC storage, plus the return, enable and
// disable commands. Precedence in one cycle: write, return, enable, disable.
module sysctl_state
    import sysctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [DW-1:0]    wr_data,
    input  logic             eret_cmd,
    input  logic             ei_cmd,
    input  logic             di_cmd,
    output logic [DW-1:0]    status_q,
    output logic [DW-1:0]    config_q,
    output logic [DW-1:0]    epc_q,
    output logic [DW-1:0]    errepc_q,
    output logic [DW-1:0]    ret_pc_q,
    output logic             ret_valid_q
);
    logic ie_allowed;

    // Enable/disable is legal in kernel mode or with any exception/EDI bit.
    always_comb begin
        ie_allowed = status_q[ST_EDI] | status_q[ST_EXL] | status_q[ST_ERL] |
                     (status_q[ST_KSU_HI:ST_KSU_LO] == 2'b00);
    end

    // Register writes and command effects, in precedence order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q    <= '0;
            config_q    <= CFG_FIX_VAL;
            epc_q       <= '0;
            errepc_q    <= '0;
            ret_pc_q    <= '0;
            ret_valid_q <= 1'b0;
        end else begin
            ret_valid_q <= 1'b0;
            if (wr_en) begin
                case (wr_sel)
                    SEL_STATUS: status_q <= wr_data;
                    SEL_CONFIG: config_q <= (wr_data & ~CFG_FIX_MASK) | CFG_FIX_VAL;
                    SEL_EPC:    epc_q    <= wr_data;
                    SEL_ERREPC: errepc_q <= wr_data;
                    default: ;
                endcase
            end else if (eret_cmd) begin
                ret_valid_q <= 1'b1;
                if (status_q[ST_ERL]) begin
                    ret_pc_q         <= errepc_q;
                    status_q[ST_ERL] <= 1'b0;
                end else begin
                    ret_pc_q         <= epc_q;
                    status_q[ST_EXL] <= 1'b0;
                end
            end else if ((ei_cmd || di_cmd) && ie_allowed) begin
                status_q[ST_EIE] <= ei_cmd;
            end
        end
    end

    AST_ERET_ERL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_cmd && !wr_en && status_q[ST_ERL]) |=> (!status_q[ST_ERL] && (status_q[ST_EXL] == $past(status_q[ST_EXL])))); // R6
    AST_ERET_EXL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_cmd && !wr_en && !status_q[ST_ERL]) |=> !status_q[ST_EXL]); // R7
    AST_IE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((ei_cmd || di_cmd) && !wr_en && !eret_cmd && !ie_allowed) |=> $stable(status_q)); // R9
    AST_IE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ei_cmd && !wr_en && !eret_cmd && ie_allowed) |=> status_q[ST_EIE]); // R8
endmodule

// File: rtl/sysctl_cond.sv
// Coprocessor branch condition: true when every channel is either done or
// not enabled. Purely combinational.
module sysctl_cond #(
    parameter int CH_W = 10
) (
    input  logic [CH_W-1:0] chan_done,
    input  logic [CH_W-1:0] chan_enable,
    output logic            cond_true
);
    // Reduce the per-channel pass terms.
    always_comb begin
        cond_true = &(chan_done | ~chan_enable);
    end
endmodule

// File: rtl/sysctl_regs.sv
// Top of the system control block: instantiates state, Count and condition
// logic and registers the selected read value. Assumes at most one operation
// per clock from the requester.
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int CH_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    output logic [DW-1:0]    rd_data,
    input  logic             eret_cmd,
    input  logic             ei_cmd,
    input  logic             di_cmd,
    output logic [DW-1:0]    ret_pc,
    output logic             ret_valid,
    input  logic [CH_W-1:0]  chan_done,
    input  logic [CH_W-1:0]  chan_enable,
    output logic             cond_true
);
    logic [DW-1:0] status_w, config_w, epc_w, errepc_w, count_rd_w;
    logic          cnt_rd, cnt_wr;

    // Count access decode.
    always_comb begin
        cnt_rd = rd_en && (reg_sel == SEL_COUNT);
        cnt_wr = wr_en && (reg_sel == SEL_COUNT);
    end

    sysctl_state u_state (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(reg_sel),
        .wr_data(wr_data), .eret_cmd(eret_cmd), .ei_cmd(ei_cmd),
        .di_cmd(di_cmd), .status_q(status_w), .config_q(config_w),
        .epc_q(epc_w), .errepc_q(errepc_w), .ret_pc_q(ret_pc),
        .ret_valid_q(ret_valid)
    );

    sysctl_count u_count (
        .clk(clk), .rst_n(rst_n), .acc_rd(cnt_rd), .acc_wr(cnt_wr),
        .wr_data(wr_data), .count_rd(count_rd_w)
    );

    sysctl_cond #(.CH_W(CH_W)) u_cond (
        .chan_done(chan_done), .chan_enable(chan_enable), .cond_true(cond_true)
    );

    // Registered read mux with per-register masking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            case (reg_sel)
                SEL_STATUS: rd_data <= status_w & STATUS_RD_MASK;
                SEL_CONFIG: rd_data <= config_w;
                SEL_COUNT:  rd_data <= count_rd_w;
                SEL_EPC:    rd_data <= epc_w;
                SEL_ERREPC: rd_data <= errepc_w;
                default:    rd_data <= '0;
            endcase
        end
    end

    AST_CFG_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (config_w[11:6] == 6'b010001)); // R3
    AST_RET_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_cmd && !wr_en) |=> ret_valid); // R6
    AST_RET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !eret_cmd |=> !ret_valid); // R6
endmodule

// File: tb/sysctl_regs_bench.sv
module sysctl_regs_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  reg_sel = '0;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        eret_cmd = 1'b0, ei_cmd = 1'b0, di_cmd = 1'b0;
    logic [31:0] ret_pc;
    logic        ret_valid;
    logic [9:0]  chan_done = '0, chan_enable = '0;
    logic        cond_true;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysctl_regs u_sysctl_regs (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rd_en(rd_en),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .eret_cmd(eret_cmd), .ei_cmd(ei_cmd), .di_cmd(di_cmd),
        .ret_pc(ret_pc), .ret_valid(ret_valid), .chan_done(chan_done),
        .chan_enable(chan_enable), .cond_true(cond_true)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic do_write(input logic [4:0] sel, input logic [31:0] d);
        reg_sel = sel; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [4:0] sel, output logic [31:0] d);
        reg_sel = sel; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic test_reset();
        logic [31:0] v;
        rst_n = 1'b0;
        idle(3);
        check("R1 ret_valid in reset", {31'd0, ret_valid}, 32'd0);
        rst_n = 1'b1;
        do_read(5'd9, v);
        check("R5 first Count read adds 1", v, 32'd1);
        do_read(5'd12, v); check("R1 Status", v, 32'd0);
        do_read(5'd16, v); check("R1 Config", v, 32'h440);
        do_read(5'd14, v); check("R1 EPC", v, 32'd0);
        do_read(5'd30, v); check("R1 ErrorEPC", v, 32'd0);
        check("R1 ret_valid", {31'd0, ret_valid}, 32'd0);
    endtask

    task automatic test_masks();
        logic [31:0] v;
        do_write(5'd12, 32'hFFFF_FFFF);
        do_read(5'd12, v); check("R2 Status read mask", v, 32'hF0C7_9C1F);
        do_write(5'd16, 32'hFFFF_FFFF);
        do_read(5'd16, v); check("R3 Config all ones", v, 32'hFFFF_F47F);
        do_write(5'd16, 32'h0);
        do_read(5'd16, v); check("R3 Config zero", v, 32'h440);
        do_write(5'd14, 32'hDEAD_BEEF);
        do_read(5'd14, v); check("R11 EPC full width", v, 32'hDEAD_BEEF);
        do_read(5'd7, v); check("R11 unmapped reads 0", v, 32'd0);
        do_write(5'd12, 32'h0);
    endtask

    task automatic test_count();
        logic [31:0] v;
        do_write(5'd9, 32'd100);
        idle(2);
        do_read(5'd9, v); check("R4 Count after 3 cycles", v, 32'd103);
        do_read(5'd9, v); check("R4 Count back-to-back", v, 32'd104);
        do_write(5'd9, 32'hFFFF_FFFF);
        do_read(5'd9, v); check("R4 Count wrap", v, 32'd0);
    endtask

    task automatic test_eret();
        logic [31:0] v;
        do_write(5'd14, 32'h0000_1000);
        do_write(5'd30, 32'h0000_2000);
        do_write(5'd12, 32'h0000_0006);
        eret_cmd = 1'b1; @(negedge clk); eret_cmd = 1'b0;
        check("R6 ret_valid pulse", {31'd0, ret_valid}, 32'd1);
        check("R6 ret_pc ErrorEPC", ret_pc, 32'h2000);
        do_read(5'd12, v); check("R6 ERL cleared, EXL kept", v, 32'h2);
        check("R6 ret_valid one cycle", {31'd0, ret_valid}, 32'd0);
        eret_cmd = 1'b1; @(negedge clk); eret_cmd = 1'b0;
        check("R7 ret_pc EPC", ret_pc, 32'h1000);
        do_read(5'd12, v); check("R7 EXL cleared", v, 32'h0);
    endtask

    task automatic test_ie();
        logic [31:0] v;
        do_write(5'd12, 32'h0000_0010);      // user mode, nothing else
        ei_cmd = 1'b1; @(negedge clk); ei_cmd = 1'b0;
        do_read(5'd12, v); check("R9 enable blocked", v, 32'h10);
        do_write(5'd12, 32'h0002_0010);      // EDI set
        ei_cmd = 1'b1; @(negedge clk); ei_cmd = 1'b0;
        do_read(5'd12, v); check("R8 enable with EDI", v, 32'h0003_0010);
        do_write(5'd12, 32'h0001_0010);      // EIE set, user mode
        di_cmd = 1'b1; @(negedge clk); di_cmd = 1'b0;
        do_read(5'd12, v); check("R9 disable blocked", v, 32'h0001_0010);
        do_write(5'd12, 32'h0001_0000);      // kernel mode
        di_cmd = 1'b1; @(negedge clk); di_cmd = 1'b0;
        do_read(5'd12, v); check("R8 disable in kernel", v, 32'h0);
    endtask

    task automatic test_cond();
        chan_done = 10'h3FF; chan_enable = 10'h3FF; #1;
        check("R10 all done", {31'd0, cond_true}, 32'd1);
        chan_done = 10'h000; chan_enable = 10'h000; #1;
        check("R10 none enabled", {31'd0, cond_true}, 32'd1);
        chan_done = 10'h3FE; chan_enable = 10'h001; #1;
        check("R10 bit0 pending", {31'd0, cond_true}, 32'd0);
        chan_done = 10'h1FF; chan_enable = 10'h200; #1;
        check("R10 bit9 pending", {31'd0, cond_true}, 32'd0);
    endtask

    initial begin
        @(negedge clk);
        test_reset();
        test_masks();
        test_count();
        test_eret();
        test_ie();
        test_cond();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule